// File: doc/BRIEF.md
# SMBus Register Target

This block is a byte-oriented two-wire serial target that lets a host read and write a small file of 8-bit registers. A system clock oversamples SCL and SDA. The target acknowledges its own device address and then takes a register address byte. After that the host either writes data bytes or issues a repeated START and reads them back. In both directions the register pointer advances by one after every data byte, so a single transaction can cover a run of consecutive registers.

The register file has two kinds of bits. Ordinary bits keep whatever the host wrote. Self-clearing bits pulse for one system-clock cycle and then drop back to zero. Register 0 holds override enables. Bit k of register 0 decides whether register k+1 or a hardware-supplied value appears on the effective output for that slot. The rest of the chip sees the raw register contents and these gated values.

Top module: `smb_regslave`

## Requirements
- R1: After reset every register holds its RST_VAL byte and the target does not pull SDA low; with default parameters register 2 reads 0x30 and all other registers read 0x00.
- R2: The target drives ACK (SDA low) in the ninth clock only for an address byte whose upper 7 bits equal DEV_ADDR (default 0x2C, so 0x58 writes and 0x59 reads). For any other address it stays silent and ignores the bus until the next START.
- R3: The sequence START, address with write bit (bit 0 = 0), register address byte, data byte stores the data in the addressed register, and the target acknowledges each of the three bytes.
- R4: Data bytes that follow without a STOP go to successive register addresses, and each one is acknowledged.
- R5: After a register address is written, a repeated START and the address with the read bit (bit 0 = 1) make the target return register bytes MSB first, starting at the pointer. The pointer advances after each byte. After a host NACK the target releases SDA.
- R6: A bit named in SC_MASK (default: bits 1 and 0 of register 7) reads 1 for exactly one system-clock cycle after a write of 1 and then returns to 0. The other bits of the same register keep the written value.
- R7: For slot j (1 to NUM_REGS-1), eff_o shows register j while bit j-1 of register 0 is 1, and shows the hw_i byte for slot j while that bit is 0.
- R8: Writes to register addresses at or above NUM_REGS are acknowledged but change no register. Reads from those addresses return 0x00, including when the pointer steps past the last register.
- R9: After a STOP the target does not drive SDA, and bytes clocked without a new START get no ACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| hw_i | input | (NUM_REGS-1)*8 | Hardware values, one byte per slot 1..NUM_REGS-1 |
| sda_oe | output | 1 | When 1, pull SDA low (open drain) |
| regs_o | output | NUM_REGS*8 | Raw register contents, register k at byte k |
| eff_o | output | (NUM_REGS-1)*8 | Override-gated values for slots 1..NUM_REGS-1 |

## Verification
The bench uses the default build: eight registers, device address 0x2C, a non-zero reset byte in register 2 and self-clearing bits 1:0 in register 7. Eight registers are few enough that a single read starting at register 7 steps past the end of the file, so the out-of-range read path and pointer overrun appear in a normal transaction. The self-clearing bits sit in the last register next to an ordinary bit, which shows that only the masked bits drop. The override bit for that register can be set in the same test.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK
  } smb_state_e;

  // Next register pointer; wraps naturally at 8 bits.
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return p + 8'd1;
  endfunction

  // Address byte carries the 7-bit device address above the R/W bit.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Override gate: hardware byte unless the enable selects the register.
  function automatic logic [7:0] gate_sel(input logic en, input logic [7:0] r,
                                          input logic [7:0] hw);
    return en ? r : hw;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;
  logic          scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[LAST-1:0], scl_i};
      sda_ff <= {sda_ff[LAST-1:0], sda_i};
      scl_d  <= scl_ff[LAST];
      sda_d  <= sda_ff[LAST];
    end
  end

  assign scl_s     = scl_ff[LAST];
  assign sda_s     = sda_ff[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  smb_state_e st, after;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       host_ack;
  logic       byte_done;

  assign byte_done = scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      after    <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      host_ack <= 1'b0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG, ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                  after  <= shreg[0] ? ST_RD : ST_REG;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_REG) begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                after  <= ST_WR;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr_next(ptr);
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
                after   <= ST_WR;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st <= after;
              if (after == ST_RD) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_RACK;
                ptr    <= ptr_next(ptr);
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  // R9: a STOP always leaves SDA released
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R2: a foreign address byte leads to silence, not an ACK
  a_r2_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && byte_done && !addr_hit(shreg, DEV_ADDR) && !start_evt && !stop_evt)
      |=> (st == ST_IDLE && !sda_oe));

  // R5: the pointer steps by one at the end of each returned byte
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && scl_fall && cnt == 4'd8 && !start_evt && !stop_evt)
      |=> ptr == ptr_next($past(ptr)));

  // R4: each data byte produces a single write strobe
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int                    NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] RST_VAL  = '0,
  parameter logic [NUM_REGS*8-1:0] SC_MASK  = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] q_all
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_all <= RST_VAL;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en && int'(wr_addr) == i)
          q_all[i*8 +: 8] <= wr_data;
        else
          q_all[i*8 +: 8] <= q_all[i*8 +: 8] & ~SC_MASK[i*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(rd_addr) == i) rd_data = q_all[i*8 +: 8];
  end

  // R6: a set self-clearing bit is gone one cycle later unless rewritten
  a_r6_sc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(q_all & SC_MASK)) && !wr_en) |=> !(|(q_all & SC_MASK)));

  // R8: writes beyond the file leave every register untouched
  a_r8_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NUM_REGS && !(|(q_all & SC_MASK))) |=> $stable(q_all));

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR    = 7'h2C,
  parameter int                    NUM_REGS    = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = 64'h0000_0000_0030_0000,
  parameter logic [NUM_REGS*8-1:0] SC_MASK     = 64'h0300_0000_0000_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [(NUM_REGS-1)*8-1:0] hw_i,
  output logic                      sda_oe,
  output logic [NUM_REGS*8-1:0]     regs_o,
  output logic [(NUM_REGS-1)*8-1:0] eff_o
);
  localparam int N_SLOTS = NUM_REGS - 1;

  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic       wr_en;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL), .SC_MASK(SC_MASK)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data), .q_all(regs_o)
  );

  for (genvar j = 1; j <= N_SLOTS; j++) begin : g_ovr
    assign eff_o[(j-1)*8 +: 8] = gate_sel(regs_o[j-1], regs_o[j*8 +: 8], hw_i[(j-1)*8 +: 8]);

    // R7: with the enable clear and hw steady, register writes do not reach the slot
    a_r7_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!regs_o[j-1] && $stable(regs_o[j-1]) && $stable(hw_i[(j-1)*8 +: 8]))
        |-> $stable(eff_o[(j-1)*8 +: 8]));
  end

endmodule

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  localparam int         CLK_P = 10;
  localparam int         Q     = 8;
  localparam logic [7:0] AW    = 8'h58;
  localparam logic [7:0] AR    = 8'h59;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_h = 1'b1;
  logic [55:0] hw = 56'h77_6655_4433_2211;
  wire         sda_oe;
  wire  [63:0] regs;
  wire  [55:0] eff;
  wire         sda_line = sda_h & ~sda_oe;

  int errs = 0;
  int checks = 0;
  int sc_hi = 0;

  always #(CLK_P/2) clk = ~clk;

  smb_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .hw_i(hw),
    .sda_oe(sda_oe), .regs_o(regs), .eff_o(eff)
  );

  always @(negedge clk) if (regs[57] | regs[56]) sc_hi++;

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic bstart();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0;
    end
    sda_h = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_line;
    scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; scl = 1'b0;
    end
    sda_h = ~give_ack; wq(); scl = 1'b1; wq(); scl = 1'b0;
    sda_h = 1'b1;
  endtask

  task automatic wr1(input string r, input logic [7:0] ra, input logic [7:0] d);
    logic a;
    bstart();
    send_byte(AW, a); chk({r, " addr ack"}, a, 1);
    send_byte(ra, a); chk({r, " reg ack"}, a, 1);
    send_byte(d, a);  chk({r, " data ack"}, a, 1);
    bstop();
  endtask

  task automatic rd_start(input string r, input logic [7:0] ra);
    logic a;
    bstart();
    send_byte(AW, a); chk({r, " addr ack"}, a, 1);
    send_byte(ra, a); chk({r, " reg ack"}, a, 1);
    bstart();
    send_byte(AR, a); chk({r, " read addr ack"}, a, 1);
  endtask

  task automatic t_reset();
    chk("R1 sda released", sda_oe, 0);
    chk("R1 reset values", regs, 64'h0000_0000_0030_0000);
    chk("R7 hw passes when enables clear", eff, hw);
  endtask

  task automatic t_foreign();
    logic a;
    bstart();
    send_byte(8'h50, a); chk("R2 foreign addr nack", a, 0);
    send_byte(8'h01, a); chk("R2 ignored after nack", a, 0);
    send_byte(8'hFF, a); chk("R2 ignored data", a, 0);
    bstop();
    chk("R2 regs untouched", regs, 64'h0000_0000_0030_0000);
  endtask

  task automatic t_single();
    wr1("R3", 8'h01, 8'h5A);
    chk("R3 reg1 written", regs[15:8], 8'h5A);
  endtask

  task automatic t_seq();
    logic a;
    bstart();
    send_byte(AW, a);    chk("R4 addr ack", a, 1);
    send_byte(8'h03, a); chk("R4 reg ack", a, 1);
    send_byte(8'h11, a); chk("R4 data0 ack", a, 1);
    send_byte(8'h22, a); chk("R4 data1 ack", a, 1);
    send_byte(8'h33, a); chk("R4 data2 ack", a, 1);
    bstop();
    chk("R4 regs 3..5", regs[47:24], 24'h33_2211);
  endtask

  task automatic t_read();
    logic [7:0] b;
    rd_start("R5", 8'h03);
    recv_byte(1, b); chk("R5 byte0", b, 8'h11);
    recv_byte(1, b); chk("R5 byte1", b, 8'h22);
    recv_byte(0, b); chk("R5 byte2", b, 8'h33);
    wq();
    chk("R5 sda released after nack", sda_oe, 0);
    bstop();
    rd_start("R1", 8'h02);
    recv_byte(0, b); chk("R1 reset value read", b, 8'h30);
    bstop();
  endtask

  task automatic t_selfclear();
    sc_hi = 0;
    wr1("R6", 8'h07, 8'h83);
    wq();
    chk("R6 pulse length", sc_hi, 1);
    chk("R6 plain bit kept", regs[63:56], 8'h80);
  endtask

  task automatic t_override();
    wr1("R7", 8'h00, 8'h01);
    chk("R7 slot1 shows reg", eff[7:0], 8'h5A);
    chk("R7 other slots hw", eff[55:8], hw[55:8]);
    wr1("R7", 8'h00, 8'h40);
    chk("R7 slot7 shows reg", eff[55:48], 8'h80);
    chk("R7 slot1 back to hw", eff[7:0], 8'h11);
  endtask

  task automatic t_oob();
    logic [63:0] snap;
    logic [7:0]  b;
    snap = regs;
    wr1("R8", 8'h20, 8'hEE);
    chk("R8 write ignored", regs, snap);
    rd_start("R8", 8'h20);
    recv_byte(0, b); chk("R8 read zero", b, 8'h00);
    bstop();
    rd_start("R8", 8'h07);
    recv_byte(1, b); chk("R8 last reg", b, 8'h80);
    recv_byte(0, b); chk("R8 past end zero", b, 8'h00);
    bstop();
  endtask

  task automatic t_idle();
    logic a;
    logic [63:0] snap;
    snap = regs;
    send_byte(AW, a);    chk("R9 no ack without start", a, 0);
    send_byte(8'h01, a); chk("R9 still silent", a, 0);
    bstop();
    chk("R9 regs unchanged", regs, snap);
    chk("R9 sda released", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_foreign();
    t_single();
    t_seq();
    t_read();
    t_selfclear();
    t_override();
    t_oob();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule